// File: doc/BRIEF.md
# Load Data Alignment and Extension Unit

This unit sits at the write-back end of a load path. It receives the 32-bit word fetched from memory, the two low address bits, a load-kind code, the current value of the destination register and a 16-bit immediate. From these it forms the 32-bit value to be written into the register file.

It covers byte and halfword loads with sign or zero extension and full-word loads. It also builds the upper-immediate constant. For unaligned left and right partial-word loads, it merges the chosen memory bytes into the old register contents and keeps the register bytes that the load does not cover.

Byte lanes are numbered big-endian: offset 0 is bits 31:24 and offset 3 is bits 7:0. The datapath is purely combinational. A parameter, `REG_OUT`, selects whether the result leaves through one output register or straight from the logic.

Top module: `ld_align_unit`

## Requirements
- R1: Kind code 0 (word) returns `mem_word` unchanged for every offset.
- R2: Kind code 1 (signed byte) selects the byte at offset k, which is bits 31-8k down to 24-8k. It copies bit 7 of that byte into result bits 31:8.
- R3: Kind code 2 (unsigned byte) selects the same byte lane as R2 and clears result bits 31:8.
- R4: Kind code 3 (signed halfword) takes bits 31:16 when offset bit 1 is 0 and bits 15:0 when it is 1, then sign-extends the result. Offset bit 0 has no effect.
- R5: Kind code 4 (unsigned halfword) selects the same halfword as R4 and clears result bits 31:16.
- R6: Kind code 5 (upper immediate) produces `{imm, 16'h0000}`. Neither `mem_word` nor `rd_old` affects the result.
- R7: Kind code 6 (left partial) at offset k places memory bytes k..3 into result bytes 0..3-k, filling downward from bit 31. The low k bytes of `rd_old` are kept.
- R8: Kind code 7 (right partial) at offset k places memory bytes 0..k into the low k+1 bytes of the result. The high 3-k bytes of `rd_old` are kept.
- R9: With `REG_OUT`=1, `result` and `out_valid` appear one clock after an accepted `in_valid`. `result` holds its value while `in_valid` is low. A synchronous active-high reset clears both `result` and `out_valid` to zero.
- R10: With `REG_OUT`=0, `result` follows the inputs in the same cycle and `out_valid` equals `in_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Inputs carry a load to be formed |
| kind | input | 3 | Load-kind code (see R1 to R8) |
| offset | input | 2 | Low address bits, big-endian byte lane |
| mem_word | input | 32 | Word read from memory |
| rd_old | input | 32 | Current destination register value |
| imm | input | 16 | Immediate for the upper-immediate kind |
| out_valid | output | 1 | `result` is valid |
| result | output | 32 | Value to write back |

## Verification
The hardest cases to reach are the partial-word merges at the extreme offsets. A left load at offset 3 takes one memory byte and keeps three register bytes, and a right load at offset 3 replaces the whole register. In both cases a lane-shift error is masked unless memory and register bytes are distinct in every lane.

The stimulus therefore sweeps all eight kinds across all four offsets. It uses memory and register patterns whose bytes all differ and that have the top bit of each byte set, so extension errors also show. A long run of mixed random loads follows. Both a registered and a combinational instance are compared against a byte-array model on every clock.

// File: rtl/ld_align_pkg.sv
package ld_align_pkg;

    localparam int WORD_W = 32;
    localparam int BYTE_W = 8;
    localparam int HALF_W = 2 * BYTE_W;
    localparam int NBYTES = WORD_W / BYTE_W;
    localparam int OFF_W  = $clog2(NBYTES);
    localparam int SH_W   = $clog2(WORD_W) + 1;
    localparam int IMM_W  = HALF_W;

    typedef enum logic [2:0] {
        LK_WORD   = 3'd0,
        LK_BYTE_S = 3'd1,
        LK_BYTE_U = 3'd2,
        LK_HALF_S = 3'd3,
        LK_HALF_U = 3'd4,
        LK_UPPER  = 3'd5,
        LK_LEFT   = 3'd6,
        LK_RIGHT  = 3'd7
    } load_kind_e;

    typedef struct packed {
        load_kind_e           kind;
        logic [OFF_W-1:0]     off;
        logic [WORD_W-1:0]    mem;
        logic [WORD_W-1:0]    rd;
        logic [IMM_W-1:0]     imm;
    } ld_req_t;

    // bit distance from the top of the word down to lane n (big-endian)
    function automatic logic [SH_W-1:0] lane_bits(input logic [OFF_W-1:0] n);
        return SH_W'(n) * SH_W'(BYTE_W);
    endfunction

    function automatic logic [WORD_W-1:0] extend(input logic [WORD_W-1:0] v,
                                                  input logic [SH_W-1:0]   width,
                                                  input logic              signed_ext);
        logic [WORD_W-1:0] keep;
        logic              top;
        keep = ~({WORD_W{1'b1}} << width);
        top  = v[width - SH_W'(1)];
        return (v & keep) | ((signed_ext && top) ? ~keep : '0);
    endfunction

endpackage

// File: rtl/ld_lane_extract.sv
module ld_lane_extract
    import ld_align_pkg::*;
(
    input  logic [WORD_W-1:0] mem,
    input  logic [OFF_W-1:0]  off,
    input  logic              is_half,
    input  logic              signed_ext,
    output logic [WORD_W-1:0] value
);
    logic [SH_W-1:0]   byte_sh;
    logic [SH_W-1:0]   half_sh;
    logic [WORD_W-1:0] aligned;

    always_comb begin
        // lane 0 sits at the top, so shift right by the bits below the lane
        byte_sh = SH_W'(WORD_W - BYTE_W) - lane_bits(off);
        half_sh = off[OFF_W-1] ? '0 : SH_W'(HALF_W);
        aligned = mem >> (is_half ? half_sh : byte_sh);
        value   = extend(aligned, is_half ? SH_W'(HALF_W) : SH_W'(BYTE_W), signed_ext);
    end
endmodule

// File: rtl/ld_partial_merge.sv
module ld_partial_merge
    import ld_align_pkg::*;
(
    input  logic [WORD_W-1:0] mem,
    input  logic [WORD_W-1:0] rd,
    input  logic [OFF_W-1:0]  off,
    output logic [WORD_W-1:0] left_val,
    output logic [WORD_W-1:0] right_val
);
    logic [SH_W-1:0]   l_sh;
    logic [SH_W-1:0]   r_sh;
    logic [SH_W-1:0]   r_fill;
    logic [WORD_W-1:0] l_keep;
    logic [WORD_W-1:0] r_keep;

    always_comb begin
        l_sh      = lane_bits(off);
        l_keep    = ~({WORD_W{1'b1}} << l_sh);
        left_val  = (mem << l_sh) | (rd & l_keep);

        r_sh      = SH_W'(WORD_W - BYTE_W) - lane_bits(off);
        r_fill    = lane_bits(off) + SH_W'(BYTE_W);
        r_keep    = (r_fill >= SH_W'(WORD_W)) ? '0 : ({WORD_W{1'b1}} << r_fill);
        right_val = (mem >> r_sh) | (rd & r_keep);
    end
endmodule

// File: rtl/ld_align_unit.sv
module ld_align_unit
    import ld_align_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [2:0]        kind,
    input  logic [OFF_W-1:0]  offset,
    input  logic [WORD_W-1:0] mem_word,
    input  logic [WORD_W-1:0] rd_old,
    input  logic [IMM_W-1:0]  imm,
    output logic              out_valid,
    output logic [WORD_W-1:0] result
);
    ld_req_t           req;
    logic [WORD_W-1:0] ext_val;
    logic [WORD_W-1:0] left_val;
    logic [WORD_W-1:0] right_val;
    logic [WORD_W-1:0] next_val;
    logic              is_half;
    logic              is_signed;

    always_comb begin
        req.kind = load_kind_e'(kind);
        req.off  = offset;
        req.mem  = mem_word;
        req.rd   = rd_old;
        req.imm  = imm;
        is_half   = (req.kind == LK_HALF_S) || (req.kind == LK_HALF_U);
        is_signed = (req.kind == LK_HALF_S) || (req.kind == LK_BYTE_S);
    end

    ld_lane_extract u_extract (
        .mem        (req.mem),
        .off        (req.off),
        .is_half    (is_half),
        .signed_ext (is_signed),
        .value      (ext_val)
    );

    ld_partial_merge u_merge (
        .mem       (req.mem),
        .rd        (req.rd),
        .off       (req.off),
        .left_val  (left_val),
        .right_val (right_val)
    );

    always_comb begin
        unique case (req.kind)
            LK_WORD:  next_val = req.mem;
            LK_UPPER: next_val = {req.imm, {(WORD_W-IMM_W){1'b0}}};
            LK_LEFT:  next_val = left_val;
            LK_RIGHT: next_val = right_val;
            default:  next_val = ext_val;
        endcase
    end

    generate
        if (REG_OUT) begin : g_reg
            logic              v_q;
            logic [WORD_W-1:0] r_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    v_q <= 1'b0;
                    r_q <= '0;
                end else begin
                    v_q <= in_valid;
                    if (in_valid) r_q <= next_val;
                end
            end
            assign out_valid = v_q;
            assign result    = r_q;
        end else begin : g_comb
            assign out_valid = in_valid;
            assign result    = next_val;
        end
    endgenerate
endmodule

// File: rtl/ld_align_checker.sv
module ld_align_checker
    import ld_align_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [2:0]        kind,
    input logic [OFF_W-1:0]  offset,
    input logic [WORD_W-1:0] mem_word,
    input logic [WORD_W-1:0] rd_old,
    input logic [IMM_W-1:0]  imm,
    input logic              out_valid,
    input logic [WORD_W-1:0] result
);
    logic [2:0]        k_q;
    logic [OFF_W-1:0]  o_q;
    logic [WORD_W-1:0] m_q;
    logic [WORD_W-1:0] r_q;
    logic [IMM_W-1:0]  i_q;
    logic              seen_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_q <= 1'b0;
            k_q <= '0; o_q <= '0; m_q <= '0; r_q <= '0; i_q <= '0;
        end else if (in_valid) begin
            seen_q <= 1'b1;
            k_q <= kind; o_q <= offset; m_q <= mem_word; r_q <= rd_old; i_q <= imm;
        end
    end

    logic [2:0]        ok;
    logic [OFF_W-1:0]  oo;
    logic [WORD_W-1:0] om;
    logic [WORD_W-1:0] orr;
    logic [IMM_W-1:0]  oi;
    logic              chk;

    assign ok  = REG_OUT ? k_q : kind;
    assign oo  = REG_OUT ? o_q : offset;
    assign om  = REG_OUT ? m_q : mem_word;
    assign orr = REG_OUT ? r_q : rd_old;
    assign oi  = REG_OUT ? i_q : imm;
    assign chk = out_valid && (REG_OUT ? seen_q : 1'b1);

    a_r1_word_passthrough: assert property (@(posedge clk) disable iff (rst)
        chk && ok == 3'd0 |-> result == om);
    a_r2_byte_sign_fill: assert property (@(posedge clk) disable iff (rst)
        chk && ok == 3'd1 |-> result[31:8] == {24{result[7]}});
    a_r3_byte_zero_fill: assert property (@(posedge clk) disable iff (rst)
        chk && ok == 3'd2 |-> result[31:8] == 24'h0);
    a_r4_half_sign_fill: assert property (@(posedge clk) disable iff (rst)
        chk && ok == 3'd3 |-> result[31:16] == {16{result[15]}});
    a_r5_half_low_select: assert property (@(posedge clk) disable iff (rst)
        chk && ok == 3'd4 && oo[1] |-> result == {16'h0, om[15:0]});
    a_r6_upper_imm: assert property (@(posedge clk) disable iff (rst)
        chk && ok == 3'd5 |-> result == {oi, 16'h0});
    a_r7_left_last_lane: assert property (@(posedge clk) disable iff (rst)
        chk && ok == 3'd6 && oo == 2'd3 |-> result == {om[7:0], orr[23:0]});
    a_r8_right_first_lane: assert property (@(posedge clk) disable iff (rst)
        chk && ok == 3'd7 && oo == 2'd0 |-> result == {orr[31:8], om[31:24]});

    generate
        if (REG_OUT) begin : g_reg_chk
            a_r9_valid_follows: assert property (@(posedge clk) disable iff (rst)
                in_valid |=> out_valid);
            a_r9_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
                !in_valid |=> $stable(result));
        end else begin : g_comb_chk
            a_r10_valid_same_cycle: assert property (@(posedge clk) disable iff (rst)
                out_valid == in_valid);
        end
    endgenerate
endmodule

bind ld_align_unit ld_align_checker #(.REG_OUT(REG_OUT)) u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .kind(kind), .offset(offset),
    .mem_word(mem_word), .rd_old(rd_old), .imm(imm),
    .out_valid(out_valid), .result(result)
);

// File: tb/ld_align_unit_test.sv
module ld_align_unit_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [2:0]  kind = '0;
    logic [1:0]  offset = '0;
    logic [31:0] mem_word = '0;
    logic [31:0] rd_old = '0;
    logic [15:0] imm = '0;
    logic        out_valid, c_valid;
    logic [31:0] result, c_result;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;
    logic [31:0] expect_q = '0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    ld_align_unit #(.REG_OUT(1'b1)) uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .kind(kind), .offset(offset),
        .mem_word(mem_word), .rd_old(rd_old), .imm(imm),
        .out_valid(out_valid), .result(result));

    ld_align_unit #(.REG_OUT(1'b0)) uut_comb (
        .clk(clk), .rst(rst), .in_valid(in_valid), .kind(kind), .offset(offset),
        .mem_word(mem_word), .rd_old(rd_old), .imm(imm),
        .out_valid(c_valid), .result(c_result));

    function automatic string tag_of(input int k);
        case (k)
            0: return "R1";
            1: return "R2";
            2: return "R3";
            3: return "R4";
            4: return "R5";
            5: return "R6";
            6: return "R7";
            default: return "R8";
        endcase
    endfunction

    function automatic logic [31:0] model(input int k, input int off,
                                          input logic [31:0] m, input logic [31:0] r,
                                          input logic [15:0] im);
        logic [7:0] mb [4];
        logic [7:0] rb [4];
        logic [7:0] ob [4];
        logic [15:0] h;
        for (int i = 0; i < 4; i++) begin
            mb[i] = m[31-8*i -: 8];
            rb[i] = r[31-8*i -: 8];
        end
        h = (off >= 2) ? m[15:0] : m[31:16];
        case (k)
            0: return m;
            1: return {{24{mb[off][7]}}, mb[off]};
            2: return {24'h0, mb[off]};
            3: return {{16{h[15]}}, h};
            4: return {16'h0, h};
            5: return {im, 16'h0};
            6: begin
                for (int j = 0; j < 4; j++) ob[j] = (j + off <= 3) ? mb[j + off] : rb[j];
                return {ob[0], ob[1], ob[2], ob[3]};
            end
            default: begin
                for (int j = 0; j < 4; j++) ob[j] = (j >= 3 - off) ? mb[j - (3 - off)] : rb[j];
                return {ob[0], ob[1], ob[2], ob[3]};
            end
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // drive one load at a falling edge; the comb copy is checked right away,
    // the registered copy after the next rising edge
    task automatic issue(input int k, input int off, input logic [31:0] m,
                         input logic [31:0] r, input logic [15:0] im);
        logic [31:0] e;
        e = model(k, off, m, r, im);
        in_valid = 1'b1; kind = 3'(k); offset = 2'(off);
        mem_word = m; rd_old = r; imm = im;
        #1;
        check({tag_of(k), " R10 comb"}, c_result, e);
        check("R10 comb valid", {31'h0, c_valid}, 32'h1);
        @(negedge clk);
        check({tag_of(k), " R9 reg"}, result, e);
        check("R9 valid", {31'h0, out_valid}, 32'h1);
        expect_q = e;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R9 reset result", result, 32'h0);
        check("R9 reset valid", {31'h0, out_valid}, 32'h0);
        rst = 1'b0;
        @(negedge clk);

        // full sweep with distinct bytes, top bit set in each
        for (int k = 0; k < 8; k++)
            for (int o = 0; o < 4; o++) begin
                issue(k, o, 32'h8A9BACBD, 32'hC1D2E3F4, 16'h9E37);
                issue(k, o, 32'h01234567, 32'h76543210, 16'h1234);
            end

        // R4 / R5: offset bit 0 has no effect on the halfword chosen
        issue(3, 1, 32'h80017FFE, 32'h0, 16'h0);
        issue(4, 3, 32'h80017FFE, 32'h0, 16'h0);
        // R6: memory and register contents do not matter
        issue(5, 2, 32'hFFFFFFFF, 32'hFFFFFFFF, 16'h00A5);

        // R9: result holds while idle even when inputs move
        in_valid = 1'b0; kind = 3'd0; mem_word = 32'hDEADBEEF;
        @(negedge clk);
        check("R9 idle valid", {31'h0, out_valid}, 32'h0);
        check("R9 hold", result, expect_q);
        @(negedge clk);
        check("R9 hold 2", result, expect_q);
        check("R10 comb idle valid", {31'h0, c_valid}, 32'h0);

        // mixed random loads
        for (int i = 0; i < 400; i++)
            issue($urandom_range(7), $urandom_range(3), $urandom, $urandom, 16'($urandom));

        // reset in the middle clears the registered output
        rst = 1'b1; in_valid = 1'b0;
        @(negedge clk);
        check("R9 reset clears result", result, 32'h0);
        check("R9 reset clears valid", {31'h0, out_valid}, 32'h0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule